// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Receiver

This block is the receive side of a serial port running in synchronous shift-register mode. Software arms it by setting an enable bit while the completion flag is clear. The block then samples the shared data line once per machine cycle, which is once per `mc_tick` pulse, and assembles a byte. When the byte is complete, the block moves it into a holding buffer and raises a completion flag.

The shift register does not use a bit counter. When reception begins, the register is loaded with all ones except a single zero in the rightmost position. Each sample enters at the right, so the zero moves one place to the left per sample. When the zero reaches the leftmost position, the block takes one final sample and then transfers the byte.

The completion flag stays set until software clears it with `done_clr`. While the flag is set, no new reception can start. If the enable bit is cleared during a reception, the reception is abandoned.

Top module: `ssr_rx_top`

## Requirements
- R1: After reset, `rx_done` is 0, `rx_busy` is 0 and `rx_data` is all zeros.
- R2: A reception starts only on a `mc_tick` pulse where `rx_en` is 1 and `rx_done` is 0. Ticks with `rx_en` at 0 leave `rx_busy` at 0.
- R3: The register is preloaded on the tick after the starting tick, and `rx_busy` rises on that same edge. `rx_busy` is therefore 1 after the second qualifying tick and 0 after only the first.
- R4: `rx_pin` is sampled only on edges where `mc_tick` is 1. Changes to the pin between ticks have no effect on the received byte.
- R5: Reception ends on the 8th sampling tick after `rx_busy` rises. On that edge, `rx_done` becomes 1 and `rx_busy` becomes 0 together. After 7 samples, `rx_done` is still 0.
- R6: The first bit sampled appears in `rx_data[0]`, and the last bit sampled appears in `rx_data[7]`.
- R7: While `rx_done` is 1, ticks with `rx_en` at 1 start nothing. `rx_busy` stays 0 and `rx_data` holds its value.
- R8: A one-cycle `done_clr` pulse clears `rx_done`. A new reception can then start and delivers a new byte.
- R9: Clearing `rx_en` during a reception drops `rx_busy` one clock later. In that case `rx_done` stays 0 and `rx_data` keeps its previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| rx_pin | input | 1 | Serial data line |
| rx_en | input | 1 | Receive enable bit |
| done_clr | input | 1 | One-clock pulse that clears the completion flag |
| rx_data | output | DATA_W | Received byte buffer, first bit in bit 0 |
| rx_done | output | 1 | Completion flag |
| rx_busy | output | 1 | High while bits are being sampled |

## Verification
The bench uses three kinds of bytes: walking single ones, alternating patterns, and all-ones/all-zeros. Walking ones confirm each bit position and the bit order. Alternating patterns expose an off-by-one in the number of samples taken. Constant bytes show whether the zero marker is confused with received zeros.

Seeded random bytes with random gaps between ticks follow. Random noise is driven on the pin between ticks, which separates true per-tick sampling from sampling on every clock. Directed cases cover three more situations: a start attempt while the flag is set, an abort at several bit positions, and ticks that arrive while the block is disabled.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ARM  = 2'd1,
    RX_RECV = 2'd2
  } rx_state_e;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mc_tick,
  input  logic rx_en,
  input  logic done_q,
  input  logic marker_hit,
  output logic preload,
  output logic shift_en,
  output logic finish,
  output logic busy
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    preload  = 1'b0;
    shift_en = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (mc_tick && rx_en && !done_q) state_d = RX_ARM;
      end
      RX_ARM: begin
        if (!rx_en) state_d = RX_IDLE;
        else if (mc_tick) begin
          preload = 1'b1;
          state_d = RX_RECV;
        end
      end
      RX_RECV: begin
        if (!rx_en) state_d = RX_IDLE;
        else if (mc_tick) begin
          shift_en = 1'b1;
          if (marker_hit) begin
            finish  = 1'b1;
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == RX_RECV);

  // R7: a pending flag blocks any new start
  assert_no_start_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && done_q) |=> (state_q == RX_IDLE));

  // R9: losing the enable returns to idle
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != RX_IDLE && !rx_en) |=> (state_q == RX_IDLE));

  // R3: armed state advances on the next qualifying tick
  assert_arm_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_ARM && mc_tick && rx_en) |=> (state_q == RX_RECV));
endmodule

// File: rtl/ssr_shreg.sv
module ssr_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preload,
  input  logic              shift_en,
  input  logic              rx_pin,
  output logic              marker_hit,
  output logic [DATA_W-1:0] shifted
);
  localparam logic [DATA_W-1:0] PRELOAD_PAT = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] sreg_q, sreg_d;

  assign shifted = {sreg_q[DATA_W-2:0], rx_pin};

  always_comb begin
    sreg_d = sreg_q;
    if (preload)       sreg_d = PRELOAD_PAT;
    else if (shift_en) sreg_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '1;
    else        sreg_q <= sreg_d;
  end

  assign marker_hit = ~sreg_q[DATA_W-1];
endmodule

// File: rtl/ssr_buf.sv
module ssr_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic [DATA_W-1:0] shifted,
  output logic [DATA_W-1:0] data_q,
  output logic              done_q
);
  logic [DATA_W-1:0] order_fix;
  logic [DATA_W-1:0] data_d;
  logic              done_d;

  // last sample sits in bit 0 of the shift register; swap so first sample lands in bit 0
  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign order_fix[g] = shifted[DATA_W-1-g];
  end

  always_comb begin
    data_d = data_q;
    done_d = done_q;
    if (clr)  done_d = 1'b0;
    if (load) begin
      data_d = order_fix;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      data_q <= data_d;
      done_q <= done_d;
    end
  end

  // R7 R9: buffer changes only on a load
  assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(data_q));
endmodule

// File: rtl/ssr_rx_top.sv
module ssr_rx_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              rx_pin,
  input  logic              rx_en,
  input  logic              done_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_busy
);
  logic              rst_n_s;
  logic              preload, shift_en, finish, marker_hit;
  logic [DATA_W-1:0] shifted;

  ssr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ssr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mc_tick    (mc_tick),
    .rx_en      (rx_en),
    .done_q     (rx_done),
    .marker_hit (marker_hit),
    .preload    (preload),
    .shift_en   (shift_en),
    .finish     (finish),
    .busy       (rx_busy)
  );

  ssr_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .preload    (preload),
    .shift_en   (shift_en),
    .rx_pin     (rx_pin),
    .marker_hit (marker_hit),
    .shifted    (shifted)
  );

  ssr_buf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (finish),
    .clr     (done_clr),
    .shifted (shifted),
    .data_q  (rx_data),
    .done_q  (rx_done)
  );

  // R5: flag rises exactly as sampling stops
  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rx_done) |-> ($past(rx_busy) && !rx_busy));

  // R4: without a tick an enabled active reception keeps going
  assert_busy_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_busy && !mc_tick && rx_en) |=> rx_busy);
endmodule

// File: tb/tb_ssr_rx_top.sv
module tb_ssr_rx_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mc_tick = 1'b0;
  logic         rx_pin = 1'b0;
  logic         rx_en = 1'b0;
  logic         done_clr = 1'b0;
  logic [W-1:0] rx_data;
  logic         rx_done;
  logic         rx_busy;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [W-1:0] last_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssr_rx_top #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .rx_pin(rx_pin),
    .rx_en(rx_en), .done_clr(done_clr), .rx_data(rx_data),
    .rx_done(rx_done), .rx_busy(rx_busy)
  );

  function automatic logic [W-1:0] expect_byte(input logic [W-1:0] bits_in_order);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = bits_in_order[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one machine cycle: drive bit, pulse tick, then noise on the pin for a gap
  task automatic mc(input logic b, input int gap);
    rx_pin  = b;
    mc_tick = 1'b1;
    @(negedge clk);
    mc_tick = 1'b0;
    for (int k = 0; k < gap; k++) begin
      rx_pin = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic clear_flag;
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic receive(input logic [W-1:0] b, input int gap);
    rx_en = 1'b1;
    mc(1'($urandom), gap);
    chk("R3 busy after first tick", rx_busy, 0);
    mc(1'($urandom), gap);
    chk("R3 busy after preload tick", rx_busy, 1);
    for (int i = 0; i < W; i++) begin
      mc(b[i], gap);
      if (i == W-2) chk("R5 no done after 7 samples", rx_done, 0);
    end
    chk("R5 done set", rx_done, 1);
    chk("R5 busy dropped", rx_busy, 0);
    chk("R6 R4 byte", rx_data, expect_byte(b));
    last_byte = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done", rx_done, 0);
    chk("R1 busy", rx_busy, 0);
    chk("R1 data", rx_data, 0);

    // R2: ticks while disabled start nothing
    for (int i = 0; i < 4; i++) mc(1'b0, 1);
    chk("R2 no start when disabled", rx_busy, 0);
    mc(1'b1, 1);
    chk("R2 still idle", rx_busy, 0);

    // directed patterns
    receive(8'hA5, 2);
    // R7: flag set blocks a new start
    for (int i = 0; i < 4; i++) mc(1'b0, 1);
    chk("R7 no start while flag", rx_busy, 0);
    chk("R7 data held", rx_data, 8'hA5);
    clear_flag();
    chk("R8 flag cleared", rx_done, 0);
    receive(8'h01, 1);
    clear_flag();
    receive(8'h80, 3);
    clear_flag();
    receive(8'h00, 1);
    clear_flag();
    receive(8'hFF, 2);
    clear_flag();
    receive(8'h55, 1);
    clear_flag();
    for (int j = 0; j < W; j++) begin
      receive(8'(1 << j), 1);
      clear_flag();
    end

    // R9: abort at several positions
    for (int pos = 0; pos < W; pos += 3) begin
      rx_en = 1'b1;
      mc(1'b0, 1);
      mc(1'b0, 1);
      for (int i = 0; i < pos; i++) mc(1'($urandom), 1);
      rx_en = 1'b0;
      @(negedge clk);
      chk("R9 busy dropped on abort", rx_busy, 0);
      for (int i = 0; i < W; i++) mc(1'b1, 1);
      chk("R9 no flag on abort", rx_done, 0);
      chk("R9 buffer kept", rx_data, expect_byte(last_byte));
    end

    // random bytes and gaps
    void'($urandom(32'd4242));
    for (int n = 0; n < 24; n++) begin
      receive(8'($urandom), 1 + ($urandom % 4));
      clear_flag();
    end

    rx_en = 1'b0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule